// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Driver

This block produces the drive timing for a multiplexed liquid-crystal panel with up to four common lines and a parameterised number of segment lines. It does not make voltages. Every common and segment pin carries a two-bit level code (low, middle-low, middle-high or high), and external bias circuits turn each code into a voltage. The duty and bias pair is chosen at run time from a small set of legal pairs. An illegal pair falls back to static drive and raises an error flag. The frame polarity flips on every frame, so each pixel sees zero average voltage over one alternation period.

Segment data is held in a display RAM with one row per common phase. Software writes rows through a simple write port. The row for a phase is copied into a holding register at the moment that phase begins, so a write can never change a phase that is already being driven. A build-time map marks each segment pin as either an LCD drive pin or a plain output pin. Plain output pins show a latched bit at the full rails and ignore the display RAM and the polarity.

Top module: `lcd_mux_driver`

## Requirements
- R1: While `rst_n` is low, every segment pin shows level code low, every `com_oe` bit is 0 (commons released) and `cfg_err` is 0.
- R2: After reset is released, all display RAM bits are 0, so LCD pins show the unselected waveform. The plain-output latches are 0, so those pins show code low.
- R3: Level codes are 2'b00 low, 2'b01 middle-low, 2'b10 middle-high and 2'b11 high. `duty_sel` encodes 0 static, 1 half, 2 third and 3 quarter duty. `bias_sel` encodes 0 static bias, 1 half bias, 2 third bias, and 3 is never legal.
- R4: Static drive uses common 0 only. Half duty uses commons 0-1, third duty uses commons 0-2 and quarter duty uses commons 0-3. Unused commons have `com_oe`=0 and code low. Phases run in ascending common order.
- R5: A phase lasts 4*PHASE_UNIT clocks in static drive, 2*PHASE_UNIT clocks in half duty, and PHASE_UNIT clocks in third and quarter duty. The frame therefore lasts 4*PHASE_UNIT clocks in every mode except third duty, where it lasts 3*PHASE_UNIT clocks.
- R6: Polarity starts at 0 after reset and flips at every frame boundary.
- R7: The active common is high at polarity 0 and low at polarity 1. A selected pixel (RAM bit 1) puts its segment at the opposite rail. In static drive an unselected segment follows the common level.
- R8: In half bias, inactive commons and unselected segments use code middle-high. In third bias at polarity 0, inactive commons are middle-low and unselected segments middle-high; at polarity 1 the two swap.
- R9: A duty/bias pair other than static/static, half/half, third/half, third/third, quarter/half or quarter/third runs as static drive with `cfg_err`=1.
- R10: The display row for a phase is read on the clock edge where that phase starts (row index = phase number). A RAM write that lands during a phase takes effect only when that row's phase next starts.
- R11: `duty_sel` and `bias_sel` are sampled on the first edge after reset and then only at frame boundaries. Changes at other times have no effect until the next boundary.
- R12: Segment pins set in SEG_GPO_MAP show code high or low from a latch written by `gpo_we`/`gpo_data`. The written value is visible from the next cycle. These pins ignore RAM writes, polarity and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_sel | input | 2 | Requested duty (R3 encoding) |
| bias_sel | input | 2 | Requested bias (R3 encoding) |
| ram_we | input | 1 | Display RAM row write strobe |
| ram_row | input | 2 | Row (common phase) to write |
| ram_data | input | NUM_SEG | Row data, bit j for segment j |
| gpo_we | input | 1 | Plain-output latch write strobe |
| gpo_data | input | NUM_SEG | Plain-output values, bit j for segment j |
| com_lvl | output | 8 | Common level codes, bits [2k+1:2k] for common k |
| com_oe | output | 4 | Common drive enable, 0 = released |
| seg_lvl | output | 2*NUM_SEG | Segment level codes, bits [2j+1:2j] for segment j |
| cfg_err | output | 1 | Active mode is a fallback from an illegal request |

## Verification
The hardest case to reach is a display RAM write that lands inside a phase, including a write to the row being loaded on that same edge. Such a write must stay hidden until the row's next phase. The stimulus writes rows at chosen offsets inside running phases, including the edge where the next phase loads. A reference model replays the same writes with read-before-write order. The stimulus also changes the mode request in the middle of frames, so the frame-boundary sampling of the mode and its illegal-pair fallback are checked cycle by cycle against the model.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

   localparam int MAX_COM = 4;

   typedef enum logic [1:0] {
      LV_LOW  = 2'b00,
      LV_MLO  = 2'b01,
      LV_MHI  = 2'b10,
      LV_HIGH = 2'b11
   } lvl_e;

   typedef enum logic [1:0] {
      DT_STATIC  = 2'd0,
      DT_HALF    = 2'd1,
      DT_THIRD   = 2'd2,
      DT_QUARTER = 2'd3
   } duty_e;

   typedef enum logic [1:0] {
      BS_FULL  = 2'd0,
      BS_HALF  = 2'd1,
      BS_THIRD = 2'd2,
      BS_NONE  = 2'd3
   } bias_e;

   typedef struct packed {
      duty_e duty;
      bias_e bias;
   } drive_mode_t;

   // Legal pairs: static/static, any multiplexed duty with half bias,
   // third or quarter duty with third bias.
   function automatic logic pair_ok(input logic [1:0] d, input logic [1:0] b);
      case (d)
         2'd0:    return (b == 2'd0);
         2'd1:    return (b == 2'd1);
         default: return (b == 2'd1) || (b == 2'd2);
      endcase
   endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer
   import lcd_mux_pkg::*;
#(
   parameter int PHASE_UNIT = 128
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  duty_sel,
   input  logic [1:0]  bias_sel,
   output logic        run,
   output logic [1:0]  phase,
   output logic        pol,
   output drive_mode_t mode,
   output logic        cfg_err,
   output logic        row_load,
   output logic [1:0]  row_next
);

   localparam int LONG_LEN = 4 * PHASE_UNIT;
   localparam int CNT_W    = (LONG_LEN > 2) ? $clog2(LONG_LEN) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_m1;
   logic             phase_end;
   logic             frame_end;
   logic             legal_in;
   drive_mode_t      mode_in;

   always_comb begin
      legal_in     = pair_ok(duty_sel, bias_sel);
      mode_in.duty = legal_in ? duty_e'(duty_sel) : DT_STATIC;
      mode_in.bias = legal_in ? bias_e'(bias_sel) : BS_FULL;
      case (mode.duty)
         DT_STATIC: len_m1 = CNT_W'(4 * PHASE_UNIT - 1);
         DT_HALF:   len_m1 = CNT_W'(2 * PHASE_UNIT - 1);
         default:   len_m1 = CNT_W'(PHASE_UNIT - 1);
      endcase
      phase_end = run && (cnt_q == len_m1);
      frame_end = phase_end && (phase == 2'(mode.duty));
      row_load  = !run || phase_end;
      row_next  = (!run || frame_end) ? 2'd0 : phase + 2'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         cnt_q     <= '0;
         phase     <= 2'd0;
         pol       <= 1'b0;
         mode.duty <= DT_STATIC;
         mode.bias <= BS_FULL;
         cfg_err   <= 1'b0;
      end else if (!run) begin
         run     <= 1'b1;
         cnt_q   <= '0;
         phase   <= 2'd0;
         pol     <= 1'b0;
         mode    <= mode_in;
         cfg_err <= !legal_in;
      end else if (phase_end) begin
         cnt_q <= '0;
         phase <= row_next;
         if (frame_end) begin
            pol     <= ~pol;
            mode    <= mode_in;
            cfg_err <= !legal_in;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= len_m1));

   p_err_static_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (mode.duty == DT_STATIC && mode.bias == BS_FULL));

   p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_end) |=> $stable(mode));

   p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (phase <= 2'(mode.duty)));

endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram
   import lcd_mux_pkg::*;
#(
   parameter int NUM_SEG = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_row,
   input  logic [NUM_SEG-1:0] wr_data,
   input  logic               row_load,
   input  logic [1:0]         row_next,
   output logic [NUM_SEG-1:0] row_q
);

   logic [NUM_SEG-1:0] mem_q [MAX_COM];

   for (genvar r = 0; r < MAX_COM; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem_q[r] <= '0;
         else if (wr_en && (wr_row == 2'(r)))
            mem_q[r] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         row_q <= '0;
      else if (row_load)
         row_q <= mem_q[row_next];
   end

   p_row_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !row_load |=> $stable(row_q));

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
   import lcd_mux_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic [1:0]           phase,
   input  logic                 pol,
   input  drive_mode_t          mode,
   output logic [2*MAX_COM-1:0] com_lvl,
   output logic [MAX_COM-1:0]   com_oe
);

   for (genvar k = 0; k < MAX_COM; k++) begin : g_com
      lvl_e lvl;
      logic used;
      always_comb begin
         used = run && (2'(k) <= 2'(mode.duty));
         if (!used)
            lvl = LV_LOW;
         else if (phase == 2'(k))
            lvl = pol ? LV_LOW : LV_HIGH;
         else if (mode.bias == BS_THIRD)
            lvl = pol ? LV_MHI : LV_MLO;
         else
            lvl = LV_MHI;
      end
      assign com_lvl[2*k +: 2] = lvl;
      assign com_oe[k]         = used;
   end

   logic [2:0] rail_cnt;
   always_comb begin
      rail_cnt = '0;
      for (int k = 0; k < MAX_COM; k++)
         if (com_oe[k] && (com_lvl[2*k +: 2] == LV_HIGH || com_lvl[2*k +: 2] == LV_LOW))
            rail_cnt = rail_cnt + 3'd1;
   end

   p_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (rail_cnt == 3'd1));

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
   import lcd_mux_pkg::*;
#(
   parameter int                 NUM_SEG     = 16,
   parameter logic [NUM_SEG-1:0] SEG_GPO_MAP = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 pol,
   input  drive_mode_t          mode,
   input  logic [NUM_SEG-1:0]   row,
   input  logic                 gpo_we,
   input  logic [NUM_SEG-1:0]   gpo_data,
   output logic [2*NUM_SEG-1:0] seg_lvl
);

   logic [NUM_SEG-1:0] gpo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gpo_q <= '0;
      else if (gpo_we)
         gpo_q <= gpo_data;
   end

   for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
      lvl_e lcd_lvl;
      lvl_e pin_lvl;
      always_comb begin
         if (row[j])
            lcd_lvl = pol ? LV_HIGH : LV_LOW;
         else begin
            case (mode.bias)
               BS_FULL: lcd_lvl = pol ? LV_LOW : LV_HIGH;
               BS_HALF: lcd_lvl = LV_MHI;
               default: lcd_lvl = pol ? LV_MLO : LV_MHI;
            endcase
         end
         if (!run)
            pin_lvl = LV_LOW;
         else if (SEG_GPO_MAP[j])
            pin_lvl = gpo_q[j] ? LV_HIGH : LV_LOW;
         else
            pin_lvl = lcd_lvl;
      end
      assign seg_lvl[2*j +: 2] = pin_lvl;

      if (SEG_GPO_MAP[j]) begin : g_gpo_chk
         p_gpo_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (run && $past(run) && !$past(gpo_we)) |-> $stable(seg_lvl[2*j +: 2]));
      end
   end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
   import lcd_mux_pkg::*;
#(
   parameter int                 NUM_SEG     = 16,
   parameter int                 PHASE_UNIT  = 128,
   parameter logic [NUM_SEG-1:0] SEG_GPO_MAP = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           duty_sel,
   input  logic [1:0]           bias_sel,
   input  logic                 ram_we,
   input  logic [1:0]           ram_row,
   input  logic [NUM_SEG-1:0]   ram_data,
   input  logic                 gpo_we,
   input  logic [NUM_SEG-1:0]   gpo_data,
   output logic [2*MAX_COM-1:0] com_lvl,
   output logic [MAX_COM-1:0]   com_oe,
   output logic [2*NUM_SEG-1:0] seg_lvl,
   output logic                 cfg_err
);

   if (NUM_SEG < 1) begin : g_bad_nseg
      $error("lcd_mux_driver: NUM_SEG must be at least 1");
   end
   if (PHASE_UNIT < 1) begin : g_bad_unit
      $error("lcd_mux_driver: PHASE_UNIT must be at least 1");
   end

   logic               run;
   logic [1:0]         phase;
   logic               pol;
   drive_mode_t        mode;
   logic               row_load;
   logic [1:0]         row_next;
   logic [NUM_SEG-1:0] row_q;

   lcd_phase_timer #(.PHASE_UNIT(PHASE_UNIT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .duty_sel (duty_sel),
      .bias_sel (bias_sel),
      .run      (run),
      .phase    (phase),
      .pol      (pol),
      .mode     (mode),
      .cfg_err  (cfg_err),
      .row_load (row_load),
      .row_next (row_next)
   );

   lcd_disp_ram #(.NUM_SEG(NUM_SEG)) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ram_we),
      .wr_row   (ram_row),
      .wr_data  (ram_data),
      .row_load (row_load),
      .row_next (row_next),
      .row_q    (row_q)
   );

   lcd_com_drv u_com (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .phase   (phase),
      .pol     (pol),
      .mode    (mode),
      .com_lvl (com_lvl),
      .com_oe  (com_oe)
   );

   lcd_seg_drv #(.NUM_SEG(NUM_SEG), .SEG_GPO_MAP(SEG_GPO_MAP)) u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .pol      (pol),
      .mode     (mode),
      .row      (row_q),
      .gpo_we   (gpo_we),
      .gpo_data (gpo_data),
      .seg_lvl  (seg_lvl)
   );

endmodule

// File: tb/tb_lcd_mux_driver.sv
module tb_lcd_mux_driver;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 6;
   localparam int U  = 3;
   localparam logic [NS-1:0] MAP = 6'b100100;
   localparam logic [1:0] L_LO = 2'b00, L_ML = 2'b01, L_MH = 2'b10, L_HI = 2'b11;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      duty_sel = 2'd0, bias_sel = 2'd0;
   logic            ram_we = 1'b0;
   logic [1:0]      ram_row = 2'd0;
   logic [NS-1:0]   ram_data = '0;
   logic            gpo_we = 1'b0;
   logic [NS-1:0]   gpo_data = '0;
   logic [7:0]      com_lvl;
   logic [3:0]      com_oe;
   logic [2*NS-1:0] seg_lvl;
   logic            cfg_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_mux_driver #(.NUM_SEG(NS), .PHASE_UNIT(U), .SEG_GPO_MAP(MAP)) dut (
      .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .bias_sel(bias_sel),
      .ram_we(ram_we), .ram_row(ram_row), .ram_data(ram_data),
      .gpo_we(gpo_we), .gpo_data(gpo_data),
      .com_lvl(com_lvl), .com_oe(com_oe), .seg_lvl(seg_lvl), .cfg_err(cfg_err)
   );

   typedef struct {
      logic [7:0]      com;
      logic [3:0]      oe;
      logic [2*NS-1:0] seg;
      logic            err;
      string           tag;
   } exp_t;

   exp_t  sb_q[$];
   int    n_checks = 0;
   int    n_fails  = 0;
   string cur_tag  = "R1";

   // reference model state
   bit            m_run, m_pol, m_err;
   int            m_cnt, m_phase, m_duty, m_bias;
   logic [NS-1:0] m_ram [4];
   logic [NS-1:0] m_row, m_gpo;

   function automatic bit legal(int d, int b);
      if (d == 0) return b == 0;
      if (d == 1) return b == 1;
      return (b == 1) || (b == 2);
   endfunction

   function automatic int plen(int d);
      if (d == 0) return 4 * U;
      if (d == 1) return 2 * U;
      return U;
   endfunction

   function automatic void take_mode();
      if (legal(duty_sel, bias_sel)) begin
         m_duty = duty_sel; m_bias = bias_sel; m_err = 1'b0;
      end else begin
         m_duty = 0; m_bias = 0; m_err = 1'b1;
      end
   endfunction

   function automatic void model_step();
      if (!rst_n) begin
         m_run = 0; m_pol = 0; m_err = 0; m_cnt = 0; m_phase = 0;
         m_duty = 0; m_bias = 0; m_row = '0; m_gpo = '0;
         for (int r = 0; r < 4; r++) m_ram[r] = '0;
         return;
      end
      if (!m_run) begin
         m_run = 1; m_cnt = 0; m_phase = 0; m_pol = 0;
         take_mode();
         m_row = m_ram[0];
      end else if (m_cnt == plen(m_duty) - 1) begin
         m_cnt = 0;
         if (m_phase == m_duty) begin
            m_phase = 0; m_pol = !m_pol; take_mode();
         end else begin
            m_phase = m_phase + 1;
         end
         m_row = m_ram[m_phase];
      end else begin
         m_cnt = m_cnt + 1;
      end
      if (ram_we) m_ram[ram_row] = ram_data;
      if (gpo_we) m_gpo = gpo_data;
   endfunction

   function automatic exp_t expect_now();
      exp_t e;
      e.tag = cur_tag;
      e.err = m_err;
      for (int k = 0; k < 4; k++) begin
         if (!m_run || k > m_duty) begin
            e.com[2*k +: 2] = L_LO; e.oe[k] = 1'b0;
         end else begin
            e.oe[k] = 1'b1;
            if (k == m_phase)  e.com[2*k +: 2] = m_pol ? L_LO : L_HI;
            else if (m_bias == 2) e.com[2*k +: 2] = m_pol ? L_MH : L_ML;
            else               e.com[2*k +: 2] = L_MH;
         end
      end
      for (int j = 0; j < NS; j++) begin
         if (!m_run)             e.seg[2*j +: 2] = L_LO;
         else if (MAP[j])        e.seg[2*j +: 2] = m_gpo[j] ? L_HI : L_LO;
         else if (m_row[j])      e.seg[2*j +: 2] = m_pol ? L_HI : L_LO;
         else if (m_bias == 0)   e.seg[2*j +: 2] = m_pol ? L_LO : L_HI;
         else if (m_bias == 1)   e.seg[2*j +: 2] = L_MH;
         else                    e.seg[2*j +: 2] = m_pol ? L_ML : L_MH;
      end
      return e;
   endfunction

   // monitor: pops one expected item per cycle and compares
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_checks++;
         if (com_lvl !== e.com || com_oe !== e.oe || seg_lvl !== e.seg || cfg_err !== e.err) begin
            n_fails++;
            $display("FAIL %s: com=%h oe=%h seg=%h err=%b expected com=%h oe=%h seg=%h err=%b",
                     e.tag, com_lvl, com_oe, seg_lvl, cfg_err, e.com, e.oe, e.seg, e.err);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
      model_step();
      sb_q.push_back(expect_now());
      @(negedge clk);
      #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr_row(input logic [1:0] r, input logic [NS-1:0] d);
      ram_we = 1'b1; ram_row = r; ram_data = d;
      tick();
      ram_we = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] d, input logic [1:0] b);
      duty_sel = d; bias_sel = b;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      // R1: reset levels
      cur_tag = "R1";
      ticks(3);
      check(seg_lvl == '0 && com_oe == 4'h0 && !cfg_err, "R1", {com_oe, seg_lvl}, 0);

      // R2 R4 R5 R6 R7: static drive with cleared RAM
      cur_tag = "R2 R4 R5 R6 R7";
      rst_n = 1'b1;
      ticks(2 * 4 * U + 3);

      // R10: writes land inside phases, including the loading edge
      cur_tag = "R10 R7";
      ticks(2);
      wr_row(2'd0, 6'b011011);
      ticks(4 * U - 4);
      wr_row(2'd0, 6'b001010);
      ticks(3 * 4 * U);

      // R11 R3: request changes mid-frame, applied at the boundary
      cur_tag = "R11 R3";
      ticks(3);
      set_mode(2'd1, 2'd1);
      ticks(4 * U + 2);

      // R5 R6 R8: half duty, half bias with distinct rows
      cur_tag = "R5 R6 R8";
      wr_row(2'd1, 6'b010001);
      ticks(U);
      wr_row(2'd0, 6'b000011);
      ticks(3 * 4 * U);

      // R4 R8: third duty with third bias, then half bias
      cur_tag = "R4 R8 third";
      set_mode(2'd2, 2'd2);
      wr_row(2'd2, 6'b011010);
      ticks(3 * 3 * U);
      set_mode(2'd2, 2'd1);
      ticks(3 * 3 * U);

      // R4 R5: quarter duty with third bias and half bias
      cur_tag = "R4 R5 quarter";
      set_mode(2'd3, 2'd2);
      wr_row(2'd3, 6'b001001);
      ticks(U + 1);
      wr_row(2'd3, 6'b010010);
      ticks(3 * 4 * U);
      set_mode(2'd3, 2'd1);
      ticks(3 * 4 * U);

      // R9: illegal pairs fall back to static with the flag
      cur_tag = "R9";
      set_mode(2'd0, 2'd1);
      ticks(2 * 4 * U);
      check(cfg_err === 1'b1 && com_oe === 4'b0001, "R9 static fallback", {com_oe, 3'b000, cfg_err}, 8'h11);
      set_mode(2'd1, 2'd2);
      ticks(2 * 4 * U);
      check(cfg_err === 1'b1, "R9 half/third", cfg_err, 1);
      set_mode(2'd3, 2'd3);
      ticks(2 * 4 * U);
      check(cfg_err === 1'b1, "R9 bias code 3", cfg_err, 1);
      set_mode(2'd3, 2'd2);
      ticks(2 * 4 * U);
      check(cfg_err === 1'b0 && com_oe === 4'hF, "R9 legal again", {com_oe, 3'b000, cfg_err}, 8'hF0);

      // R12: plain-output pins follow their latch only
      cur_tag = "R12";
      gpo_data = 6'b111111; gpo_we = 1'b1;
      tick();
      gpo_we = 1'b0;
      check(seg_lvl[5:4] === L_HI && seg_lvl[11:10] === L_HI, "R12 latch high",
            {seg_lvl[11:10], seg_lvl[5:4]}, 4'hF);
      wr_row(2'd0, 6'b000000);
      ticks(2 * 4 * U);
      gpo_data = 6'b000100; gpo_we = 1'b1;
      tick();
      gpo_we = 1'b0;
      ticks(4 * U);
      check(seg_lvl[5:4] === L_HI && seg_lvl[11:10] === L_LO, "R12 per pin",
            {seg_lvl[11:10], seg_lvl[5:4]}, 4'h3);

      // R1 R2: reset in the middle of a run
      cur_tag = "R1 mid-run";
      rst_n = 1'b0;
      ticks(2);
      check(seg_lvl == '0 && com_oe == 4'h0, "R1 mid-run", {com_oe, seg_lvl}, 0);
      cur_tag = "R2 after reset";
      set_mode(2'd1, 2'd1);
      rst_n = 1'b1;
      ticks(2 * 4 * U);
      check(seg_lvl[5:4] === L_LO && seg_lvl[11:10] === L_LO, "R2 gpo cleared",
            {seg_lvl[11:10], seg_lvl[5:4]}, 0);

      ticks(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule